// File: doc/BRIEF.md
# Display-List DMA Request Dispatcher

This block accepts one channel-2 transfer request that copies data out of system RAM towards the graphics front end. On a start strobe it checks the global operation register, checks that the source lies in system RAM, and picks one of three destination paths: the tile-accelerator FIFO, the 64-bit texture path or the 32-bit texture path. It then issues the transfer as one or two burst commands. Each burst carries its path, source, destination and length. A transfer that would run past the end of RAM is cut at the RAM end and finished by a second burst.

Burst commands leave on a valid/ready channel. While `bc_valid_o` is high and `bc_ready_i` is low, the command is held unchanged. Each accepted command is followed by a wait for the data mover's `bd_done_i` pulse. Only after that pulse is the next command offered or the transfer finished.

On finishing, the block presents a one-cycle write-back of status and a one-cycle interrupt in the same cycle. The write-back can carry an address-error flag, or a transfer-end flag together with clears of the count, start and length registers and an optional destination write-back. The surrounding register file applies these updates. The interrupt controller is also outside this block.

Top module: `dl_dma_dispatch`

## Requirements
- R1: A start strobe is accepted only if `(op_i & 16'h8307) == 16'h8201` and the block is idle. If the operation value fails this test, the strobe causes no busy, no burst and no interrupt.
- R2: Source bits [28:26] are taken after masking with 0x1FFFFFE0. If they are not 3, no burst is issued and exactly one completion cycle follows, with `st_ae_o`=1, `st_te_o`=0 and `st_dst_we_o`=0.
- R3: If destination bit 24 is 0, bursts use path code 0 (tile FIFO). The destination sent is `dst_i & 0x01FFFFE0`, the source sent is `src_i & 0x1FFFFFE0`, and `bc_len_o` is the byte count divided by 32.
- R4: If destination bit 24 is 1, the texture path is used. Raw destination bit 25 selects `lmode1_i` when it is 1 and `lmode0_i` when it is 0. A selected mode of 0 gives path code 1 (64-bit). A selected mode of 1 gives path code 2 (32-bit).
- R5: On path 1 the destination is the low 24 bits of the masked destination ORed with 0xA4000000, and the length is in bytes. On path 2 the same low bits are ORed with 0xA5000000, and the length is counted in 32-bit words (bytes divided by 4).
- R6: Let the source offset be the low 24 bits of the masked source, with a RAM size of 0x1000000. If offset plus length exceeds the RAM size, two bursts are issued. The first has length RAM size minus offset. The second carries the rest, with the source advanced by the first length. On the texture paths the destination is also advanced by the first length. On path 0 the destination is repeated. If offset plus length equals the RAM size exactly, one burst is issued.
- R7: A burst command stays stable while it is offered and not taken. After a burst is taken, no command is offered until `bd_done_i` is seen.
- R8: A successful transfer ends with one cycle of `irq_o`=`st_we_o`=`st_te_o`=1 and `st_ae_o`=0. On the texture paths, `st_dst_we_o`=1 and `st_dst_o` equals the first issued destination plus the whole length. On path 0, `st_dst_we_o`=0.
- R9: `busy_o` is 0 after reset. It rises in the cycle after an accepted start and stays high through the interrupt cycle. It is 0 in the cycle after. Start strobes while busy are ignored.
- R10: A zero length issues no burst and goes directly to the R8 completion. On the texture paths the written-back destination is the remapped start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| op_i | input | 16 | Global DMA operation register value |
| src_i | input | 32 | Source address |
| dst_i | input | 32 | Destination address |
| len_i | input | 32 | Transfer length in bytes |
| lmode0_i | input | 1 | Texture memory-mode bit for bank 0 |
| lmode1_i | input | 1 | Texture memory-mode bit for bank 1 |
| bc_valid_o | output | 1 | Burst command valid |
| bc_ready_i | input | 1 | Burst command ready |
| bc_path_o | output | 2 | Burst path: 0 tile FIFO, 1 texture 64-bit, 2 texture 32-bit |
| bc_src_o | output | 32 | Burst source address |
| bc_dst_o | output | 32 | Burst destination address |
| bc_len_o | output | 32 | Burst length in path units |
| bd_done_i | input | 1 | Data mover finished the last accepted burst |
| busy_o | output | 1 | Request in progress |
| irq_o | output | 1 | Channel-2 completion interrupt pulse |
| st_we_o | output | 1 | Status write-back strobe |
| st_ae_o | output | 1 | Set the address-error flag |
| st_te_o | output | 1 | Set transfer end; clear count, start and length |
| st_dst_we_o | output | 1 | Write `st_dst_o` into the destination status register |
| st_dst_o | output | 32 | Final destination address |

## Verification
A wrongly captured request shows at the ports on the first offered burst, in the cycle after start. A path, remap or mask error shows in `bc_path_o`, `bc_dst_o` or `bc_src_o`. A split error shows one burst later as a wrong length or a missing second command.

A sequencer state fault shows in one of three ways: as an offer during the wait for `bd_done_i`, as a command that changes under back-pressure, or as `busy_o` and the interrupt pulse out of step in the completion cycle. A faulty legality check shows as activity after a start that should have been dropped, or as a missing address-error write-back, within two cycles.

// File: rtl/dl_dma_pkg.sv
package dl_dma_pkg;

  localparam int DL_AW      = 32;
  localparam int DL_LW      = 32;
  localparam int DL_NB_MAX  = 2;
  localparam int TA_UNIT_LG = 5;
  localparam int WORD_LG    = 2;

  typedef enum logic [1:0] {
    PATH_TA    = 2'd0,
    PATH_TEX64 = 2'd1,
    PATH_TEX32 = 2'd2
  } dl_path_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_OFFER = 2'd1,
    S_WAIT  = 2'd2,
    S_DONE  = 2'd3
  } dl_state_e;

  typedef struct packed {
    logic [DL_AW-1:0] src;
    logic [DL_AW-1:0] dst;
    logic [DL_LW-1:0] bytes;
  } dl_burst_t;

  function automatic logic [DL_LW-1:0] dl_units(dl_path_e p, logic [DL_LW-1:0] b);
    case (p)
      PATH_TA:    return b >> TA_UNIT_LG;
      PATH_TEX32: return b >> WORD_LG;
      default:    return b;
    endcase
  endfunction

endpackage

// File: rtl/dl_req_decode.sv
module dl_req_decode
  import dl_dma_pkg::*;
#(
  parameter int RAM_AW      = 24,
  parameter logic [DL_AW-1:0] SRC_MASK = 32'h1FFF_FFE0,
  parameter logic [DL_AW-1:0] DST_MASK = 32'h01FF_FFE0,
  parameter int REGION_LSB  = 26,
  parameter int REGION_W    = 3,
  parameter logic [REGION_W-1:0] REGION_ID = 3'd3,
  parameter int TEX_BIT     = 24,
  parameter int BANK_BIT    = 25,
  parameter int REMAP_W     = 24,
  parameter logic [DL_AW-REMAP_W-1:0] TEX64_HI = 8'hA4,
  parameter logic [DL_AW-REMAP_W-1:0] TEX32_HI = 8'hA5
) (
  input  logic [DL_AW-1:0] src_i,
  input  logic [DL_AW-1:0] dst_i,
  input  logic [DL_LW-1:0] len_i,
  input  logic             lmode0_i,
  input  logic             lmode1_i,
  output logic             src_ok_o,
  output logic             tex_o,
  output dl_path_e         path_o,
  output logic [1:0]       nb_o,
  output dl_burst_t        bursts_o [DL_NB_MAX],
  output logic [DL_AW-1:0] final_dst_o
);

  localparam logic [DL_LW:0] RAM_BYTES = (DL_LW+1)'(1) << RAM_AW;

  logic [DL_AW-1:0] src_m, dst_m, base;
  logic [DL_LW:0]   off, reach;
  logic             split, mode_sel;
  logic [DL_LW-1:0] len_a, len_b;

  always_comb begin
    src_m    = src_i & SRC_MASK;
    dst_m    = dst_i & DST_MASK;
    src_ok_o = (src_m[REGION_LSB +: REGION_W] == REGION_ID);
    tex_o    = dst_m[TEX_BIT];
    mode_sel = dst_i[BANK_BIT] ? lmode1_i : lmode0_i;

    if (!tex_o)        path_o = PATH_TA;
    else if (mode_sel) path_o = PATH_TEX32;
    else               path_o = PATH_TEX64;

    case (path_o)
      PATH_TEX64: base = {TEX64_HI, dst_m[REMAP_W-1:0]};
      PATH_TEX32: base = {TEX32_HI, dst_m[REMAP_W-1:0]};
      default:    base = dst_m;
    endcase

    off   = (DL_LW+1)'(src_m[RAM_AW-1:0]);
    reach = off + {1'b0, len_i};
    split = reach > RAM_BYTES;
    len_a = split ? DL_LW'(RAM_BYTES - off) : len_i;
    len_b = len_i - len_a;

    if (len_i == '0)  nb_o = 2'd0;
    else if (split)   nb_o = 2'd2;
    else              nb_o = 2'd1;

    final_dst_o = base + DL_AW'(len_i);
  end

  for (genvar g = 0; g < DL_NB_MAX; g++) begin : g_slot
    if (g == 0) begin : g_first
      assign bursts_o[g].src   = src_m;
      assign bursts_o[g].dst   = base;
      assign bursts_o[g].bytes = len_a;
    end else begin : g_rest
      assign bursts_o[g].src   = src_m + DL_AW'(len_a);
      assign bursts_o[g].dst   = tex_o ? base + DL_AW'(len_a) : base;
      assign bursts_o[g].bytes = len_b;
    end
  end

endmodule

// File: rtl/dl_burst_seq.sv
module dl_burst_seq
  import dl_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             src_ok_i,
  input  logic             tex_i,
  input  dl_path_e         path_i,
  input  logic [1:0]       nb_i,
  input  dl_burst_t        bursts_i [DL_NB_MAX],
  input  logic [DL_AW-1:0] final_dst_i,
  output logic             bc_valid_o,
  input  logic             bc_ready_i,
  output logic [1:0]       bc_path_o,
  output logic [DL_AW-1:0] bc_src_o,
  output logic [DL_AW-1:0] bc_dst_o,
  output logic [DL_LW-1:0] bc_len_o,
  input  logic             bd_done_i,
  output logic             busy_o,
  output logic             irq_o,
  output logic             st_we_o,
  output logic             st_ae_o,
  output logic             st_te_o,
  output logic             st_dst_we_o,
  output logic [DL_AW-1:0] st_dst_o
);

  dl_state_e        state_q;
  logic             idx_q;
  logic [1:0]       nb_q;
  logic             ok_q, tex_q;
  dl_path_e         path_q;
  dl_burst_t        slot_q [DL_NB_MAX];
  logic [DL_AW-1:0] fdst_q;
  logic             last_w;

  assign last_w = ({1'b0, idx_q} + 2'd1) >= nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= 1'b0;
      nb_q    <= '0;
      ok_q    <= 1'b0;
      tex_q   <= 1'b0;
      path_q  <= PATH_TA;
      fdst_q  <= '0;
      for (int i = 0; i < DL_NB_MAX; i++) slot_q[i] <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (go_i) begin
          idx_q  <= 1'b0;
          nb_q   <= nb_i;
          ok_q   <= src_ok_i;
          tex_q  <= tex_i;
          path_q <= path_i;
          fdst_q <= final_dst_i;
          for (int i = 0; i < DL_NB_MAX; i++) slot_q[i] <= bursts_i[i];
          if (!src_ok_i || nb_i == 2'd0) state_q <= S_DONE;
          else                           state_q <= S_OFFER;
        end
        S_OFFER: if (bc_ready_i) state_q <= S_WAIT;
        S_WAIT: if (bd_done_i) begin
          if (last_w) state_q <= S_DONE;
          else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_OFFER;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bc_valid_o  = (state_q == S_OFFER);
    bc_path_o   = path_q;
    bc_src_o    = slot_q[idx_q].src;
    bc_dst_o    = slot_q[idx_q].dst;
    bc_len_o    = dl_units(path_q, slot_q[idx_q].bytes);
    busy_o      = (state_q != S_IDLE);
    irq_o       = (state_q == S_DONE);
    st_we_o     = irq_o;
    st_ae_o     = irq_o & ~ok_q;
    st_te_o     = irq_o & ok_q;
    st_dst_we_o = irq_o & ok_q & tex_q;
    st_dst_o    = fdst_q;
  end

endmodule

// File: rtl/dl_dma_dispatch.sv
module dl_dma_dispatch
  import dl_dma_pkg::*;
#(
  parameter int OP_W = 16,
  parameter logic [OP_W-1:0] OP_MASK = 16'h8307,
  parameter logic [OP_W-1:0] OP_GOOD = 16'h8201,
  parameter int RAM_AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [DL_AW-1:0] src_i,
  input  logic [DL_AW-1:0] dst_i,
  input  logic [DL_LW-1:0] len_i,
  input  logic             lmode0_i,
  input  logic             lmode1_i,
  output logic             bc_valid_o,
  input  logic             bc_ready_i,
  output logic [1:0]       bc_path_o,
  output logic [DL_AW-1:0] bc_src_o,
  output logic [DL_AW-1:0] bc_dst_o,
  output logic [DL_LW-1:0] bc_len_o,
  input  logic             bd_done_i,
  output logic             busy_o,
  output logic             irq_o,
  output logic             st_we_o,
  output logic             st_ae_o,
  output logic             st_te_o,
  output logic             st_dst_we_o,
  output logic [DL_AW-1:0] st_dst_o
);

  logic             op_ok, go;
  logic             src_ok, tex;
  dl_path_e         path;
  logic [1:0]       nb;
  dl_burst_t        bursts [DL_NB_MAX];
  logic [DL_AW-1:0] final_dst;

  assign op_ok = ((op_i & OP_MASK) == OP_GOOD);
  assign go    = start_i & op_ok & ~busy_o;

  dl_req_decode #(.RAM_AW(RAM_AW)) u_dec (
    .src_i       (src_i),
    .dst_i       (dst_i),
    .len_i       (len_i),
    .lmode0_i    (lmode0_i),
    .lmode1_i    (lmode1_i),
    .src_ok_o    (src_ok),
    .tex_o       (tex),
    .path_o      (path),
    .nb_o        (nb),
    .bursts_o    (bursts),
    .final_dst_o (final_dst)
  );

  dl_burst_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go),
    .src_ok_i    (src_ok),
    .tex_i       (tex),
    .path_i      (path),
    .nb_i        (nb),
    .bursts_i    (bursts),
    .final_dst_i (final_dst),
    .bc_valid_o  (bc_valid_o),
    .bc_ready_i  (bc_ready_i),
    .bc_path_o   (bc_path_o),
    .bc_src_o    (bc_src_o),
    .bc_dst_o    (bc_dst_o),
    .bc_len_o    (bc_len_o),
    .bd_done_i   (bd_done_i),
    .busy_o      (busy_o),
    .irq_o       (irq_o),
    .st_we_o     (st_we_o),
    .st_ae_o     (st_ae_o),
    .st_te_o     (st_te_o),
    .st_dst_we_o (st_dst_we_o),
    .st_dst_o    (st_dst_o)
  );

endmodule

// File: rtl/dl_dma_dispatch_chk.sv
module dl_dma_dispatch_chk #(
  parameter int OP_W = 16,
  parameter logic [OP_W-1:0] OP_MASK = 16'h8307,
  parameter logic [OP_W-1:0] OP_GOOD = 16'h8201
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [OP_W-1:0] op_i,
  input logic            bc_valid_o,
  input logic            bc_ready_i,
  input logic [1:0]      bc_path_o,
  input logic [31:0]     bc_src_o,
  input logic [31:0]     bc_dst_o,
  input logic [31:0]     bc_len_o,
  input logic            busy_o,
  input logic            irq_o,
  input logic            st_we_o,
  input logic            st_ae_o,
  input logic            st_te_o,
  input logic            st_dst_we_o
);

  AST_DROP_BAD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && ((op_i & OP_MASK) != OP_GOOD)) |=> !busy_o); // R1

  AST_AE_TE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    st_we_o |-> (st_ae_o != st_te_o)); // R2

  AST_TA_DST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid_o && bc_path_o == 2'd0) |-> (bc_dst_o[31:24] == 8'h00)); // R3

  AST_TEX64_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid_o && bc_path_o == 2'd1) |-> (bc_dst_o[31:24] == 8'hA4)); // R5

  AST_TEX32_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid_o && bc_path_o == 2'd2) |-> (bc_dst_o[31:24] == 8'hA5)); // R5

  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid_o && !bc_ready_i) |=> (bc_valid_o && $stable(bc_path_o) && $stable(bc_src_o)
                                     && $stable(bc_dst_o) && $stable(bc_len_o))); // R7

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid_o && bc_ready_i) |=> !bc_valid_o); // R7

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R8

  AST_DST_WB_OK: assert property (@(posedge clk) disable iff (!rst_n)
    st_dst_we_o |-> (st_te_o && irq_o)); // R8

  AST_BUSY_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> busy_o); // R9

  AST_IDLE_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !busy_o); // R9

  AST_OFFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid_o |-> busy_o); // R9

endmodule

bind dl_dma_dispatch dl_dma_dispatch_chk #(
  .OP_W(OP_W), .OP_MASK(OP_MASK), .OP_GOOD(OP_GOOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
  .bc_valid_o(bc_valid_o), .bc_ready_i(bc_ready_i), .bc_path_o(bc_path_o),
  .bc_src_o(bc_src_o), .bc_dst_o(bc_dst_o), .bc_len_o(bc_len_o),
  .busy_o(busy_o), .irq_o(irq_o), .st_we_o(st_we_o), .st_ae_o(st_ae_o),
  .st_te_o(st_te_o), .st_dst_we_o(st_dst_we_o)
);

// File: tb/sim_dl_dma_dispatch.sv
`timescale 1ns/1ps
module sim_dl_dma_dispatch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] op_i = '0;
  logic [31:0] src_i = '0, dst_i = '0, len_i = '0;
  logic        lmode0_i = 1'b0, lmode1_i = 1'b0;
  logic        bc_valid_o, bc_ready_i = 1'b0;
  logic [1:0]  bc_path_o;
  logic [31:0] bc_src_o, bc_dst_o, bc_len_o;
  logic        bd_done_i = 1'b0;
  logic        busy_o, irq_o, st_we_o, st_ae_o, st_te_o, st_dst_we_o;
  logic [31:0] st_dst_o;

  int vec_n = 0;
  int bad_n = 0;

  always #10 clk = ~clk;

  dl_dma_dispatch u0 (.*);

  // collected results
  int          g_nb, g_irq, g_wait_offer, g_hold_err, g_busy_irq, g_busy_after, g_busy_max;
  logic [1:0]  g_path [4];
  logic [31:0] g_src [4], g_dst [4], g_len [4];
  logic        g_ae, g_te, g_dwe;
  logic [31:0] g_sdst;

  // expected results
  int          e_nb;
  logic [1:0]  e_path;
  logic [31:0] e_src [2], e_dst [2], e_len [2], e_fdst;
  bit          e_tex, e_reg_ok, e_op_ok;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vec_n++;
    if (got !== exp) begin
      bad_n++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] units(input logic [1:0] p, input logic [31:0] b);
    if (p == 2'd0) return b / 32;
    if (p == 2'd2) return b / 4;
    return b;
  endfunction

  task automatic model(input logic [15:0] op, input logic [31:0] src, dst, len, input bit m0, m1);
    logic [31:0] sm, dm, base, room, first;
    bit sel;
    e_op_ok  = ((op & 16'h8307) == 16'h8201);
    sm       = src & 32'h1FFFFFE0;
    dm       = dst & 32'h01FFFFE0;
    e_reg_ok = ((sm >> 26) == 32'd3);
    e_tex    = dm[24];
    sel      = dst[25] ? m1 : m0;
    e_path   = !e_tex ? 2'd0 : (sel ? 2'd2 : 2'd1);
    if (!e_tex) base = dm;
    else base = ((e_path == 2'd1) ? 32'hA4000000 : 32'hA5000000) | (dm & 32'h00FFFFFF);
    room = 32'h01000000 - (sm & 32'h00FFFFFF);
    if (len == 0) begin e_nb = 0; first = 0; end
    else if (len > room) begin e_nb = 2; first = room; end
    else begin e_nb = 1; first = len; end
    e_src[0] = sm;          e_dst[0] = base;
    e_len[0] = units(e_path, first);
    e_src[1] = sm + first;  e_dst[1] = e_tex ? base + first : base;
    e_len[1] = units(e_path, len - first);
    e_fdst   = base + len;
    if (!e_op_ok) e_nb = 0;
    else if (!e_reg_ok) e_nb = 0;
  endtask

  task automatic run(input logic [15:0] op, input logic [31:0] src, dst, len, input bit m0, m1,
                     input int stall, input int dly, input bit restart);
    int scnt, dcnt;
    bit waiting, held, irq_seen, fin;
    logic [1:0]  h_path;
    logic [31:0] h_src, h_dst, h_len;
    g_nb = 0; g_irq = 0; g_wait_offer = 0; g_hold_err = 0;
    g_busy_irq = 0; g_busy_after = 0; g_busy_max = 0;
    g_ae = 0; g_te = 0; g_dwe = 0; g_sdst = '0;
    scnt = stall; dcnt = 0; waiting = 0; held = 0; irq_seen = 0; fin = 0;
    h_path = '0; h_src = '0; h_dst = '0; h_len = '0;
    @(negedge clk);
    op_i = op; src_i = src; dst_i = dst; len_i = len; lmode0_i = m0; lmode1_i = m1;
    start_i = 1'b1;
    @(negedge clk);
    for (int cyc = 0; cyc < 80 && !fin; cyc++) begin
      start_i = (restart && cyc == 1);
      if (busy_o) g_busy_max = 1;
      if (irq_seen) begin
        g_busy_after = busy_o;
        if (irq_o) g_irq++;
        fin = 1;
      end
      bd_done_i = 1'b0;
      if (waiting) begin
        if (dcnt == 0) begin bd_done_i = 1'b1; waiting = 0; end
        else dcnt--;
      end
      if (held && (!bc_valid_o || bc_path_o !== h_path || bc_src_o !== h_src ||
                   bc_dst_o !== h_dst || bc_len_o !== h_len)) g_hold_err++;
      held = 0;
      bc_ready_i = 1'b0;
      if (bc_valid_o) begin
        if (waiting) g_wait_offer++;
        if (scnt > 0) begin
          scnt--; held = 1;
          h_path = bc_path_o; h_src = bc_src_o; h_dst = bc_dst_o; h_len = bc_len_o;
        end else begin
          bc_ready_i = 1'b1;
          if (g_nb < 4) begin
            g_path[g_nb] = bc_path_o; g_src[g_nb] = bc_src_o;
            g_dst[g_nb] = bc_dst_o;   g_len[g_nb] = bc_len_o;
          end
          g_nb++;
          waiting = 1; dcnt = dly; scnt = stall;
        end
      end
      if (irq_o && !irq_seen) begin
        irq_seen = 1; g_irq++;
        g_busy_irq = busy_o;
        g_ae = st_ae_o; g_te = st_te_o; g_dwe = st_dst_we_o; g_sdst = st_dst_o;
        if (!st_we_o) g_hold_err++;
      end
      @(negedge clk);
    end
    start_i = 1'b0; bc_ready_i = 1'b0; bd_done_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_case(input string tag, input logic [15:0] op, input logic [31:0] src, dst, len,
                         input bit m0, m1, input int stall, input int dly, input bit restart);
    model(op, src, dst, len, m0, m1);
    run(op, src, dst, len, m0, m1, stall, dly, restart);
    chk(tag, "burst count", 32'(g_nb), 32'(e_nb));
    for (int i = 0; i < 2; i++) begin
      if (i < e_nb && i < g_nb) begin
        chk(tag, "path", 32'(g_path[i]), 32'(e_path));
        chk(tag, "src",  g_src[i], e_src[i]);
        chk(tag, "dst",  g_dst[i], e_dst[i]);
        chk(tag, "len",  g_len[i], e_len[i]);
      end
    end
    chk({tag, " R7"}, "offer while waiting / hold", 32'(g_wait_offer + g_hold_err), 32'd0);
    if (!e_op_ok) begin
      chk(tag, "irq count", 32'(g_irq), 32'd0);
      chk(tag, "busy seen", 32'(g_busy_max), 32'd0);
    end else begin
      chk(tag, "irq count", 32'(g_irq), 32'd1);
      chk({tag, " R9"}, "busy at irq", 32'(g_busy_irq), 32'd1);
      chk({tag, " R9"}, "busy after irq", 32'(g_busy_after), 32'd0);
      chk(tag, "ae", 32'(g_ae), e_reg_ok ? 32'd0 : 32'd1);
      chk(tag, "te", 32'(g_te), e_reg_ok ? 32'd1 : 32'd0);
      chk(tag, "dst_we", 32'(g_dwe), (e_reg_ok && e_tex) ? 32'd1 : 32'd0);
      if (e_reg_ok && e_tex) chk(tag, "dst writeback", g_sdst, e_fdst);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R9", "reset busy", 32'(busy_o), 32'd0);
    chk("R9", "reset valid", 32'(bc_valid_o), 32'd0);
    chk("R9", "reset irq", 32'(irq_o), 32'd0);
  endtask

  task automatic t_bad_op;
    do_case("R1", 16'h8200, 32'h0C001000, 32'h10000000, 32'h40, 0, 0, 0, 0, 0);
    do_case("R1", 16'h8205, 32'h0C001000, 32'h10000000, 32'h40, 0, 0, 0, 0, 0);
  endtask

  task automatic t_bad_src;
    do_case("R2", 16'h8201, 32'h08000000, 32'h11000000, 32'h100, 0, 0, 0, 0, 0);
    do_case("R2", 16'h8201, 32'h10001000, 32'h10000000, 32'h100, 0, 0, 0, 0, 0);
  endtask

  task automatic t_ta;
    do_case("R3", 16'h8201, 32'hAC001000, 32'h10800020, 32'h400, 0, 0, 0, 1, 0);
  endtask

  task automatic t_tex;
    do_case("R4", 16'h8201, 32'h0C002000, 32'h11000040, 32'h200, 0, 1, 3, 2, 0);
    do_case("R5", 16'h8201, 32'h0C003000, 32'h13000080, 32'h100, 0, 1, 0, 0, 0);
    do_case("R4", 16'h8201, 32'h0C004000, 32'h11000100, 32'h80, 1, 0, 1, 0, 0);
    do_case("R5", 16'h8201, 32'h0C004000, 32'h13000100, 32'h80, 1, 0, 0, 0, 0);
  endtask

  task automatic t_split;
    do_case("R6", 16'h8201, 32'h0CFFFF00, 32'h10000000, 32'h300, 0, 0, 1, 1, 0);
    do_case("R6", 16'h8201, 32'h0CFFFFC0, 32'h11000000, 32'h100, 0, 0, 0, 3, 0);
    do_case("R6", 16'h8201, 32'h0CFFFF00, 32'h11000000, 32'h100, 1, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure;
    do_case("R7", 16'h8201, 32'h0CFFFFE0, 32'h13000000, 32'h60, 0, 1, 4, 5, 0);
  endtask

  task automatic t_complete;
    do_case("R8", 16'h8201, 32'h0C010000, 32'h12000200, 32'h80, 0, 0, 0, 0, 0);
    do_case("R8", 16'h8201, 32'h0C010000, 32'h11000200, 32'h80, 0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_restart;
    do_case("R9", 16'h8201, 32'h0C020000, 32'h10000000, 32'h40, 0, 0, 2, 2, 1);
  endtask

  task automatic t_zero;
    do_case("R10", 16'h8201, 32'h0C020000, 32'h11000400, 32'h0, 0, 0, 0, 0, 0);
    do_case("R10", 16'h8201, 32'h0C020000, 32'h10000400, 32'h0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bad_op();
    t_bad_src();
    t_ta();
    t_tex();
    t_split();
    t_backpressure();
    t_complete();
    t_busy_restart();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vec_n++;
    bad_n++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
    $finish;
  end

endmodule